// File: doc/BRIEF.md
# I2S Stereo Receive Channel

This block is one receive channel of an I2S bus master. It watches the shared bit clock and word select, both sampled in the system clock domain, and shifts serial data in on each rising bit-clock edge. Each left word (word select low) and the following right word (word select high) are captured at a programmed resolution and pushed as one stereo pair into a small FIFO. Software pulls the pairs out through a left buffer register and a right buffer register over a simple register port.

Two interrupt lines report the FIFO state: data-available rises when the fill level passes a programmable threshold, and overrun rises when a complete pair arrives while the FIFO is full. Each can be masked, the overrun flag has its own clear register, and a flush register empties the FIFO. Capture runs only when four control bits are all set.

The deserializer is a three-state machine. `RX_SYNC` waits for word select to fall; the transition `SYNC->SHIFT` happens on that edge. In `RX_SHIFT` bits are collected; `SHIFT->SKIP` happens when the programmed number of bits has been taken, and `SHIFT->SHIFT` when word select toggles (word done, next word starts). In `RX_SKIP` surplus slot bits are ignored; `SKIP->SHIFT` happens when word select toggles. Any state returns to `RX_SYNC` when capture is disabled or the resolution code is unsupported.

Top module: `i2s_rx_channel`

## Requirements
- R1: After reset both interrupts are low, the FIFO is empty, the control register reads 0, the resolution code reads 0x5, the threshold reads 0 and the mask register reads 0x3.
- R2: Capture requires all four bits of the control register at 0x00 (bit 0 global, bit 1 receive block, bit 2 clock, bit 3 channel); while any is clear no pair is pushed, and clearing one abandons any partly received pair.
- R3: Data is sampled on rising bit-clock edges; word select low marks the left word and high the right word, and the MSB of a word follows the bit in which word select changed; after enabling, capture starts at the first falling word select.
- R4: The resolution code at 0x04 selects the bits kept from the start of each word: 1 = 12, 2 = 16, 3 = 20, 4 = 24, 5 = 32; the word is right-justified with the upper bits zero. Any other code captures nothing.
- R5: A pair is pushed when a right word completes after a left word; a read of 0x20 returns the oldest left word, a read of 0x24 returns the oldest right word and removes the pair; reads of either on an empty FIFO return 0 and change nothing.
- R6: The raw data-available flag is set while the fill level exceeds the threshold at 0x08; the data-available interrupt is that flag with mask bit 0 (at 0x0C) clear.
- R7: A pair arriving while the FIFO is full is dropped, the FIFO contents stay unchanged and the overrun flag is set; the overrun interrupt is that flag with mask bit 1 clear.
- R8: Any write to 0x10 clears the overrun flag; a read of 0x10 returns the flag in bit 0.
- R9: Writing 1 to bit 0 of 0x14 empties the FIFO.
- R10: The status register at 0x18 returns the raw data-available flag in bit 0, the overrun flag in bit 1 and the fill level in bits 11:8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational, zero when no read |
| bck | input | 1 | Serial bit clock |
| ws | input | 1 | Word select |
| sd | input | 1 | Serial data |
| irq_dav | output | 1 | Data-available interrupt |
| irq_ovr | output | 1 | Overrun interrupt |

## Verification
The hardest state to reach is overrun: the FIFO must be full and one more complete left and right word must arrive with no reads in between, then the dropped pair must be shown to leave the stored pairs untouched. The stimulus streams nine tagged pairs back to back without reading, checks the interrupts after the eighth and ninth, and then drains all eight pairs in order. A second hard case, a disable in the middle of a pair, is reached by writing the control register between the left and right slots and then resynchronising.

// File: rtl/i2s_rx_pkg.sv
package i2s_rx_pkg;

    localparam int WORD_W = 32;
    localparam int CNT_W  = 6;

    typedef enum logic [1:0] {
        RX_SYNC  = 2'd0,
        RX_SHIFT = 2'd1,
        RX_SKIP  = 2'd2
    } rx_state_t;

    localparam logic [7:0] OFF_CTRL   = 8'h00;
    localparam logic [7:0] OFF_RES    = 8'h04;
    localparam logic [7:0] OFF_THR    = 8'h08;
    localparam logic [7:0] OFF_MASK   = 8'h0C;
    localparam logic [7:0] OFF_OVRCLR = 8'h10;
    localparam logic [7:0] OFF_FLUSH  = 8'h14;
    localparam logic [7:0] OFF_STAT   = 8'h18;
    localparam logic [7:0] OFF_LBUF   = 8'h20;
    localparam logic [7:0] OFF_RBUF   = 8'h24;

    // Number of bits kept per word for a resolution code; zero means no capture.
    function automatic logic [CNT_W-1:0] res_bits(input logic [2:0] code);
        case (code)
            3'd1:    res_bits = 6'd12;
            3'd2:    res_bits = 6'd16;
            3'd3:    res_bits = 6'd20;
            3'd4:    res_bits = 6'd24;
            3'd5:    res_bits = 6'd32;
            default: res_bits = 6'd0;
        endcase
    endfunction

endpackage

// File: rtl/i2s_rx_deser.sv
module i2s_rx_deser
    import i2s_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [2:0]        res_code,
    input  logic              bck,
    input  logic              ws,
    input  logic              sd,
    output logic              pair_vld,
    output logic [WORD_W-1:0] pair_left,
    output logic [WORD_W-1:0] pair_right
);

    rx_state_t         state, nstate;
    logic              bck_q, ws_q, left_ok;
    logic [CNT_W-1:0]  cnt, nbits;
    logic [WORD_W-1:0] shreg, shifted, left_hold;
    logic              rise, ws_chg, active;

    assign nbits   = res_bits(res_code);
    assign active  = run && (nbits != '0);
    assign rise    = bck && !bck_q;
    assign ws_chg  = ws != ws_q;
    assign shifted = (state == RX_SHIFT) ? {shreg[WORD_W-2:0], sd} : shreg;

    always_comb begin
        nstate = state;
        if (!active) begin
            nstate = RX_SYNC;
        end else if (rise) begin
            unique case (state)
                RX_SYNC:  if (ws_q && !ws) nstate = RX_SHIFT;
                RX_SHIFT: begin
                    if (ws_chg)                     nstate = RX_SHIFT;
                    else if (cnt + 6'd1 == nbits)   nstate = RX_SKIP;
                end
                RX_SKIP:  if (ws_chg) nstate = RX_SHIFT;
                default:  nstate = RX_SYNC;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RX_SYNC;
        else        state <= nstate;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bck_q      <= 1'b0;
            ws_q       <= 1'b0;
            cnt        <= '0;
            shreg      <= '0;
            left_hold  <= '0;
            left_ok    <= 1'b0;
            pair_vld   <= 1'b0;
            pair_left  <= '0;
            pair_right <= '0;
        end else begin
            bck_q    <= bck;
            pair_vld <= 1'b0;
            if (rise) ws_q <= ws;
            if (!active || (rise && state == RX_SYNC)) begin
                cnt     <= '0;
                shreg   <= '0;
                left_ok <= 1'b0;
            end else if (rise) begin
                if (ws_chg) begin
                    cnt   <= '0;
                    shreg <= '0;
                    if (!ws_q) begin
                        left_hold <= shifted;
                        left_ok   <= 1'b1;
                    end else begin
                        left_ok <= 1'b0;
                        if (left_ok) begin
                            pair_vld   <= 1'b1;
                            pair_left  <= left_hold;
                            pair_right <= shifted;
                        end
                    end
                end else if (state == RX_SHIFT) begin
                    shreg <= shifted;
                    cnt   <= cnt + 6'd1;
                end
            end
        end
    end

endmodule

// File: rtl/i2s_rx_fifo.sv
module i2s_rx_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 64,
    localparam int AW    = $clog2(DEPTH),
    localparam int LVL_W = AW + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic             flush,
    input  logic [W-1:0]     wdata,
    output logic [W-1:0]     rdata,
    output logic [LVL_W-1:0] level,
    output logic             full,
    output logic             empty
);

    logic [W-1:0]     mem [DEPTH];
    logic [LVL_W-1:0] wptr, rptr;

    assign level = wptr - rptr;
    assign full  = level == LVL_W'(DEPTH);
    assign empty = level == '0;
    assign rdata = mem[rptr[AW-1:0]];

    always_ff @(posedge clk) begin
        if (push && !full && !flush) mem[wptr[AW-1:0]] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr <= '0;
            rptr <= '0;
        end else if (flush) begin
            wptr <= '0;
            rptr <= '0;
        end else begin
            if (push && !full) wptr <= wptr + 1'b1;
            if (pop && !empty) rptr <= rptr + 1'b1;
        end
    end

endmodule

// File: rtl/i2s_rx_channel.sv
module i2s_rx_channel
    import i2s_rx_pkg::*;
#(
    parameter int FIFO_DEPTH = 8,
    localparam int THR_W = $clog2(FIFO_DEPTH),
    localparam int LVL_W = THR_W + 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [7:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        bck,
    input  logic        ws,
    input  logic        sd,
    output logic        irq_dav,
    output logic        irq_ovr
);

    logic [3:0]         ctrl;
    logic [2:0]         res_code;
    logic [THR_W-1:0]   thr;
    logic [1:0]         mask;
    logic               ovr;
    logic               run, pair_vld, flush, ovr_clr, pop, dav_raw;
    logic [WORD_W-1:0]  pair_left, pair_right;
    logic [2*WORD_W-1:0] head;
    logic [LVL_W-1:0]   level;
    logic               full, empty;

    assign run     = &ctrl;
    assign flush   = reg_wr && reg_addr == OFF_FLUSH && reg_wdata[0];
    assign ovr_clr = reg_wr && reg_addr == OFF_OVRCLR;
    assign pop     = reg_rd && reg_addr == OFF_RBUF && !empty;
    assign dav_raw = level > LVL_W'(thr);
    assign irq_dav = dav_raw && !mask[0];
    assign irq_ovr = ovr && !mask[1];

    i2s_rx_deser u_deser (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .res_code  (res_code),
        .bck       (bck),
        .ws        (ws),
        .sd        (sd),
        .pair_vld  (pair_vld),
        .pair_left (pair_left),
        .pair_right(pair_right)
    );

    i2s_rx_fifo #(.DEPTH(FIFO_DEPTH), .W(2*WORD_W)) u_fifo (
        .clk  (clk),
        .rst_n(rst_n),
        .push (pair_vld),
        .pop  (pop),
        .flush(flush),
        .wdata({pair_left, pair_right}),
        .rdata(head),
        .level(level),
        .full (full),
        .empty(empty)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl     <= '0;
            res_code <= 3'd5;
            thr      <= '0;
            mask     <= 2'b11;
            ovr      <= 1'b0;
        end else begin
            if (reg_wr) begin
                unique case (reg_addr)
                    OFF_CTRL: ctrl     <= reg_wdata[3:0];
                    OFF_RES:  res_code <= reg_wdata[2:0];
                    OFF_THR:  thr      <= reg_wdata[THR_W-1:0];
                    OFF_MASK: mask     <= reg_wdata[1:0];
                    default: ;
                endcase
            end
            if (pair_vld && full) ovr <= 1'b1;
            else if (ovr_clr)     ovr <= 1'b0;
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_rd) begin
            unique case (reg_addr)
                OFF_CTRL:   reg_rdata = 32'(ctrl);
                OFF_RES:    reg_rdata = 32'(res_code);
                OFF_THR:    reg_rdata = 32'(thr);
                OFF_MASK:   reg_rdata = 32'(mask);
                OFF_OVRCLR: reg_rdata = 32'(ovr);
                OFF_STAT:   reg_rdata = (32'(level) << 8) | (32'(ovr) << 1) | 32'(dav_raw);
                OFF_LBUF:   reg_rdata = empty ? '0 : head[2*WORD_W-1:WORD_W];
                OFF_RBUF:   reg_rdata = empty ? '0 : head[WORD_W-1:0];
                default:    reg_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/i2s_rx_channel_chk.sv
module i2s_rx_channel_chk #(
    parameter int DEPTH = 8,
    parameter int LVL_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run,
    input logic             pair_vld,
    input logic             full,
    input logic             ovr,
    input logic             flush,
    input logic             ovr_clr,
    input logic             pop,
    input logic [LVL_W-1:0] level
);

    AST_NO_PUSH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !pair_vld);  // R2

    AST_OVR_ON_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_vld && full) |=> ovr);  // R7

    AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LVL_W'(DEPTH));  // R7

    AST_OVR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_clr && !(pair_vld && full)) |=> !ovr);  // R8

    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> level == '0);  // R9

    AST_POP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !flush && !pair_vld) |=> level == $past(level) - 1'b1);  // R5

endmodule

bind i2s_rx_channel i2s_rx_channel_chk #(.DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .pair_vld(pair_vld),
    .full    (full),
    .ovr     (ovr),
    .flush   (flush),
    .ovr_clr (ovr_clr),
    .pop     (pop),
    .level   (level)
);

// File: tb/i2s_rx_channel_bench.sv
module i2s_rx_channel_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        bck = 1'b0, ws = 1'b0, sd = 1'b0;
    logic        irq_dav, irq_ovr;

    int n_tests = 0, n_fail = 0;
    logic [63:0] model_q [$];

    always #4 clk = ~clk;

    i2s_rx_channel u_i2s_rx_channel (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .bck(bck), .ws(ws), .sd(sd), .irq_dav(irq_dav), .irq_ovr(irq_ovr)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk); reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk); reg_rd = 1'b0;
    endtask

    function automatic logic [31:0] exp_word(input logic [31:0] tx, input int code);
        int nb;
        case (code)
            1: nb = 12; 2: nb = 16; 3: nb = 20; 4: nb = 24; default: nb = 32;
        endcase
        return tx >> (32 - nb);
    endfunction

    task automatic send_bit(input logic w, input logic d);
        @(negedge clk); bck = 1'b0; ws = w; sd = d;
        @(negedge clk);
        @(negedge clk); bck = 1'b1;
        @(negedge clk);
    endtask

    task automatic send_slot(input logic w_this, input logic w_next, input logic [31:0] d);
        for (int i = 0; i < 32; i++)
            send_bit((i == 31) ? w_next : w_this, d[31-i]);
    endtask

    task automatic preamble();
        send_slot(1'b1, 1'b0, 32'h0);
    endtask

    task automatic send_pair(input logic [31:0] l, input logic [31:0] r);
        send_slot(1'b0, 1'b1, l);
        send_slot(1'b1, 1'b0, r);
        repeat (4) @(negedge clk);
    endtask

    task automatic level_is(input string req, input int n);
        logic [31:0] st;
        rd(8'h18, st);
        chk(req, 64'((st >> 8) & 32'hF), 64'(n));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] d, l, r;
        int code, np;
        void'($urandom(32'd2024));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 irq_dav", 64'(irq_dav), 0);
        chk("R1 irq_ovr", 64'(irq_ovr), 0);
        rd(8'h00, d); chk("R1 ctrl", 64'(d), 0);
        rd(8'h04, d); chk("R1 res", 64'(d), 5);
        rd(8'h08, d); chk("R1 thr", 64'(d), 0);
        rd(8'h0C, d); chk("R1 mask", 64'(d), 3);
        rd(8'h18, d); chk("R10 status after reset", 64'(d), 0);

        wr(8'h08, 32'd7);
        wr(8'h0C, 32'd0);

        // R2 channel bit clear: nothing captured
        wr(8'h00, 32'h7);
        preamble();
        send_pair(32'h1111_2222, 32'h3333_4444);
        level_is("R2 no capture with channel bit clear", 0);

        // R2/R3 all enabled
        wr(8'h00, 32'hF);
        preamble();
        send_pair(32'hA5A5_0F0F, 32'h5A5A_F0F0);
        level_is("R3 one pair pushed", 1);
        rd(8'h20, d); chk("R3 left word", 64'(d), 64'h A5A5_0F0F);
        rd(8'h24, d); chk("R3 right word", 64'(d), 64'h5A5A_F0F0);
        level_is("R5 pop on right read", 0);

        // R5 empty reads
        rd(8'h24, d); chk("R5 empty right read", 64'(d), 0);
        rd(8'h20, d); chk("R5 empty left read", 64'(d), 0);
        level_is("R5 empty read changes nothing", 0);

        // R2 mid-pair disable
        send_slot(1'b0, 1'b1, 32'hDEAD_BEEF);
        wr(8'h00, 32'hB);
        repeat (4) @(negedge clk);
        level_is("R2 partial pair abandoned", 0);
        wr(8'h00, 32'hF);
        preamble();
        send_pair(32'h0123_4567, 32'h89AB_CDEF);
        level_is("R2 resync after re-enable", 1);
        rd(8'h20, d); chk("R2 left after resync", 64'(d), 64'h0123_4567);
        rd(8'h24, d); chk("R2 right after resync", 64'(d), 64'h89AB_CDEF);

        // R4 random resolutions
        for (int it = 0; it < 10; it++) begin
            code = 1 + int'($urandom % 5);
            wr(8'h04, 32'(code));
            np = 1 + int'($urandom % 3);
            for (int k = 0; k < np; k++) begin
                l = $urandom; r = $urandom;
                send_pair(l, r);
                model_q.push_back({exp_word(l, code), exp_word(r, code)});
            end
            for (int k = 0; k < np; k++) begin
                rd(8'h20, l); rd(8'h24, r);
                chk("R4 left at resolution", 64'(l), 64'(model_q[0][63:32]));
                chk("R4 right at resolution", 64'(r), 64'(model_q[0][31:0]));
                void'(model_q.pop_front());
            end
        end

        // R4 unsupported code
        wr(8'h04, 32'd0);
        send_pair(32'hFFFF_FFFF, 32'hFFFF_FFFF);
        level_is("R4 code 0 captures nothing", 0);
        wr(8'h04, 32'd2);
        preamble();
        send_pair(32'hFEDC_BA98, 32'h8000_0001);
        rd(8'h20, d); chk("R4 16-bit left upper zero", 64'(d), 64'h0000_FEDC);
        rd(8'h24, d); chk("R4 16-bit right upper zero", 64'(d), 64'h0000_8000);
        wr(8'h04, 32'd5);

        // R6 threshold
        wr(8'h08, 32'd2);
        send_pair(32'h1, 32'h2);
        send_pair(32'h3, 32'h4);
        chk("R6 dav low at threshold", 64'(irq_dav), 0);
        send_pair(32'h5, 32'h6);
        chk("R6 dav high above threshold", 64'(irq_dav), 1);
        wr(8'h0C, 32'd1);
        chk("R6 dav masked", 64'(irq_dav), 0);
        rd(8'h18, d); chk("R10 raw dav while masked", 64'(d), 64'h301);
        wr(8'h0C, 32'd0);
        rd(8'h20, d); rd(8'h24, d);
        chk("R6 dav falls after read", 64'(irq_dav), 0);

        // R9 flush
        wr(8'h14, 32'd1);
        level_is("R9 flush empties", 0);
        rd(8'h20, d); chk("R9 read after flush", 64'(d), 0);

        // R7 overrun
        wr(8'h08, 32'd7);
        for (int k = 0; k < 8; k++) send_pair(32'h100 + 32'(k), 32'h200 + 32'(k));
        chk("R6 dav when full", 64'(irq_dav), 1);
        chk("R7 no overrun yet", 64'(irq_ovr), 0);
        send_pair(32'hBAD0, 32'hBAD1);
        chk("R7 overrun irq", 64'(irq_ovr), 1);
        rd(8'h18, d); chk("R10 status full+ovr", 64'(d), 64'h803);
        wr(8'h0C, 32'd2);
        chk("R7 overrun masked", 64'(irq_ovr), 0);
        rd(8'h10, d); chk("R8 flag before clear", 64'(d), 1);
        wr(8'h10, 32'd0);
        rd(8'h10, d); chk("R8 flag cleared", 64'(d), 0);
        wr(8'h0C, 32'd0);
        chk("R8 irq low after clear", 64'(irq_ovr), 0);
        for (int k = 0; k < 8; k++) begin
            rd(8'h20, l); rd(8'h24, r);
            chk("R7 stored left intact", 64'(l), 64'(32'h100 + 32'(k)));
            chk("R7 stored right intact", 64'(r), 64'(32'h200 + 32'(k)));
        end
        level_is("R7 dropped pair absent", 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule